// File: doc/BRIEF.md
# CAN Message Object Register Bank

This block is the storage for fifteen CAN message objects. Each object sits in a 16-byte window of a byte-addressed space. The CPU reaches every byte of it through a single read/write port. The per-object control flags are single stored bits. Each flag is written through a two-bit command field, so software can set or clear any one flag without disturbing the others and without a read-modify-write.

A reduced protocol-engine port sits on the other side. It can drop a received frame into an object and report that a transmission has finished. Both events can raise the object's interrupt pending flag. A combined interrupt line is driven from the valid objects that have an interrupt pending, together with the number of the lowest such object.

The block has no sequencing of its own. Every object updates in one cycle from the current CPU write and the current engine event. The only states are the stored flag values. In each command field, a flag moves from clear to set on code 10, from set to clear on code 01, and holds on 11 or 00.

Top module: `msgobj_bank`

## Requirements
- R1: Object n (1..15) occupies addresses n*16 to n*16+15. Offset 0 is control byte 0, offset 1 is control byte 1, offsets 2..5 are identifier bytes, offset 6 is configuration, and offsets 7..14 are data bytes. Offset 15 and all of addresses 0..15 read as 0x00 and ignore writes. Identifier, configuration and data bytes read back what was written.
- R2: In a control byte, each two-bit field is a command: 01 clears the flag, 10 sets it, and 11 or 00 leaves it unchanged. Each field acts independently of the others in the same write.
- R3: A control-byte read returns 10 in a field whose flag is set and 01 in a field whose flag is clear.
- R4: Control byte 0 fields are interrupt pending [1:0], receive interrupt enable [3:2], transmit interrupt enable [5:4] and valid [7:6]. Control byte 1 fields are new data [1:0], lost/updating [3:2], transmit request [5:4] and remote pending [7:6].
- R5: Configuration bit 3 selects transmit direction and bit 2 marks an extended identifier. The lost/updating field is one stored bit for either direction.
- R6: An engine receive store to a valid object whose direction bit is 0 loads the four identifier bytes and the eight data bytes, and sets new data. Identifier byte k is eng_id[31-8k -: 8] and data byte k is eng_data[63-8k -: 8].
- R7: A receive store that finds new data already set also sets the lost flag.
- R8: A receive store sets interrupt pending when receive interrupt enable is set.
- R9: A receive store to an invalid object, or to a transmit-direction object, changes nothing.
- R10: An engine transmit-done clears transmit request. It sets interrupt pending only if transmit interrupt enable is set.
- R11: irq is high when any valid object has interrupt pending. irq_obj then gives the lowest such object number, and it is 0 when irq is low.
- R12: After reset, every flag is clear (both control bytes read 0x55), every object is invalid and irq is low.
- R13: When a CPU control write and an engine event reach the same flag in the same cycle, the engine's result wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 8 | CPU byte address |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | CPU read byte, combinational from cpu_addr |
| eng_rx_store | input | 1 | Engine stores a received frame into eng_obj |
| eng_tx_done | input | 1 | Engine reports transmission of eng_obj finished |
| eng_obj | input | 4 | Object number addressed by the engine |
| eng_id | input | 32 | Received identifier |
| eng_data | input | 64 | Received data bytes |
| irq | output | 1 | Combined interrupt |
| irq_obj | output | 4 | Lowest valid object with interrupt pending, 0 if none |

## Verification
The assertions assume that rst_n is held low long enough for a clock edge, and that engine pulses last exactly one cycle each. They also assume that inputs change only away from the rising edge, so that a one-cycle engine pulse is seen exactly once. The stimulus drives every input on the falling edge and returns each strobe to 0 one cycle later. It uses only object numbers 1..15 for engine events, except when it deliberately aims a receive store at an object that is invalid or set to transmit. The same-cycle collision of a CPU write and an engine event is produced once, on purpose, to observe the engine-wins rule.

// File: rtl/msgobj_pkg.sv
package msgobj_pkg;

    localparam int SLOT_BYTES = 16;
    localparam int ID_BYTES   = 4;
    localparam int DATA_BYTES = 8;
    localparam int FLAGS      = 4;

    localparam logic [3:0] OFS_CTRL0 = 4'd0;
    localparam logic [3:0] OFS_CTRL1 = 4'd1;
    localparam logic [3:0] OFS_ID0   = 4'd2;
    localparam logic [3:0] OFS_CFG   = 4'd6;
    localparam logic [3:0] OFS_DATA0 = 4'd7;

    localparam int CFG_DIR_BIT = 3;

    // control byte 0 flag slots
    localparam int F0_PEND  = 0;
    localparam int F0_RXIE  = 1;
    localparam int F0_TXIE  = 2;
    localparam int F0_VALID = 3;
    // control byte 1 flag slots
    localparam int F1_NEW   = 0;
    localparam int F1_LOST  = 1;
    localparam int F1_TXREQ = 2;

    typedef enum logic [1:0] {
        FLD_HOLD0 = 2'b00,
        FLD_CLR   = 2'b01,
        FLD_SET   = 2'b10,
        FLD_HOLD  = 2'b11
    } fld_cmd_e;

    function automatic logic fld_apply(input logic cur, input logic [1:0] code);
        logic nxt;
        unique case (fld_cmd_e'(code))
            FLD_CLR:  nxt = 1'b0;
            FLD_SET:  nxt = 1'b1;
            FLD_HOLD0,
            FLD_HOLD: nxt = cur;
            default:  nxt = cur;
        endcase
        return nxt;
    endfunction

    function automatic logic [7:0] fld_pack(input logic [FLAGS-1:0] f);
        logic [7:0] b;
        for (int i = 0; i < FLAGS; i++) begin
            b[2*i +: 2] = f[i] ? FLD_SET : FLD_CLR;
        end
        return b;
    endfunction

endpackage

// File: rtl/msgobj_slot.sv
module msgobj_slot
    import msgobj_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [3:0]                 ofs,
    input  logic [7:0]                 wr_data,
    output logic [7:0]                 rd_data,
    input  logic                       rx_hit,
    input  logic                       tx_hit,
    input  logic [8*ID_BYTES-1:0]      rx_id,
    input  logic [8*DATA_BYTES-1:0]    rx_data,
    output logic                       valid_o,
    output logic                       pend_o
);

    logic [FLAGS-1:0]                c0_q, c0_n;
    logic [FLAGS-1:0]                c1_q, c1_n;
    logic [7:0]                      cfg_q, cfg_n;
    logic [ID_BYTES-1:0][7:0]        id_q, id_n;
    logic [DATA_BYTES-1:0][7:0]      dat_q, dat_n;
    logic                            rx_ok;

    assign rx_ok = rx_hit && c0_q[F0_VALID] && !cfg_q[CFG_DIR_BIT];

    always_comb begin
        c0_n  = c0_q;
        c1_n  = c1_q;
        cfg_n = cfg_q;
        id_n  = id_q;
        dat_n = dat_q;
        if (wr_en) begin
            if (ofs == OFS_CTRL0) begin
                for (int i = 0; i < FLAGS; i++) c0_n[i] = fld_apply(c0_q[i], wr_data[2*i +: 2]);
            end
            if (ofs == OFS_CTRL1) begin
                for (int i = 0; i < FLAGS; i++) c1_n[i] = fld_apply(c1_q[i], wr_data[2*i +: 2]);
            end
            if (ofs == OFS_CFG) cfg_n = wr_data;
            for (int k = 0; k < ID_BYTES; k++) begin
                if (ofs == OFS_ID0 + 4'(k)) id_n[k] = wr_data;
            end
            for (int k = 0; k < DATA_BYTES; k++) begin
                if (ofs == OFS_DATA0 + 4'(k)) dat_n[k] = wr_data;
            end
        end
        // engine events are applied last so they win a same-cycle collision
        if (rx_ok) begin
            for (int k = 0; k < ID_BYTES; k++)   id_n[k]  = rx_id[8*(ID_BYTES-1-k) +: 8];
            for (int k = 0; k < DATA_BYTES; k++) dat_n[k] = rx_data[8*(DATA_BYTES-1-k) +: 8];
            c1_n[F1_NEW] = 1'b1;
            if (c1_q[F1_NEW]) c1_n[F1_LOST] = 1'b1;
            if (c0_q[F0_RXIE]) c0_n[F0_PEND] = 1'b1;
        end
        if (tx_hit) begin
            c1_n[F1_TXREQ] = 1'b0;
            if (c0_q[F0_TXIE]) c0_n[F0_PEND] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c0_q  <= '0;
            c1_q  <= '0;
            cfg_q <= '0;
            id_q  <= '0;
            dat_q <= '0;
        end else begin
            c0_q  <= c0_n;
            c1_q  <= c1_n;
            cfg_q <= cfg_n;
            id_q  <= id_n;
            dat_q <= dat_n;
        end
    end

    always_comb begin
        rd_data = 8'h00;
        if (ofs == OFS_CTRL0) rd_data = fld_pack(c0_q);
        if (ofs == OFS_CTRL1) rd_data = fld_pack(c1_q);
        if (ofs == OFS_CFG)   rd_data = cfg_q;
        for (int k = 0; k < ID_BYTES; k++) begin
            if (ofs == OFS_ID0 + 4'(k)) rd_data = id_q[k];
        end
        for (int k = 0; k < DATA_BYTES; k++) begin
            if (ofs == OFS_DATA0 + 4'(k)) rd_data = dat_q[k];
        end
    end

    assign valid_o = c0_q[F0_VALID];
    assign pend_o  = c0_q[F0_PEND];

    p_rx_newdat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ok |=> c1_q[F1_NEW]);
    p_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ok && c1_q[F1_NEW]) |=> c1_q[F1_LOST]);
    p_rx_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ok && c0_q[F0_RXIE]) |=> c0_q[F0_PEND]);
    p_rx_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_hit && !rx_ok && !wr_en) |=> ($stable(dat_q) && $stable(id_q) && $stable(c1_q)));
    p_txdone_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_hit |=> !c1_q[F1_TXREQ]);
    p_hold_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ofs == OFS_CTRL0 && wr_data == 8'hFF && !rx_hit && !tx_hit) |=> $stable(c0_q));

endmodule

// File: rtl/msgobj_irq_pri.sv
module msgobj_irq_pri #(
    parameter int N     = 15,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i + 1);
        end
    end

    assign any = |req;

endmodule

// File: rtl/msgobj_bank.sv
module msgobj_bank
    import msgobj_pkg::*;
#(
    parameter int NUM_OBJ = 15,
    parameter int ADDR_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        cpu_addr,
    input  logic                     cpu_wr,
    input  logic [7:0]               cpu_wdata,
    output logic [7:0]               cpu_rdata,
    input  logic                     eng_rx_store,
    input  logic                     eng_tx_done,
    input  logic [ADDR_W-5:0]        eng_obj,
    input  logic [8*ID_BYTES-1:0]    eng_id,
    input  logic [8*DATA_BYTES-1:0]  eng_data,
    output logic                     irq,
    output logic [ADDR_W-5:0]        irq_obj
);

    localparam int IDX_W = ADDR_W - 4;

    logic [IDX_W-1:0]   cpu_obj;
    logic [3:0]         cpu_ofs;
    logic [7:0]         rd_arr [NUM_OBJ];
    logic [NUM_OBJ-1:0] val_vec;
    logic [NUM_OBJ-1:0] pend_vec;
    logic [NUM_OBJ-1:0] req_vec;

    assign cpu_obj = cpu_addr[ADDR_W-1:4];
    assign cpu_ofs = cpu_addr[3:0];

    for (genvar g = 0; g < NUM_OBJ; g++) begin : g_obj
        msgobj_slot u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (cpu_wr && cpu_obj == IDX_W'(g + 1)),
            .ofs     (cpu_ofs),
            .wr_data (cpu_wdata),
            .rd_data (rd_arr[g]),
            .rx_hit  (eng_rx_store && eng_obj == IDX_W'(g + 1)),
            .tx_hit  (eng_tx_done && eng_obj == IDX_W'(g + 1)),
            .rx_id   (eng_id),
            .rx_data (eng_data),
            .valid_o (val_vec[g]),
            .pend_o  (pend_vec[g])
        );
    end

    always_comb begin
        cpu_rdata = 8'h00;
        for (int i = 0; i < NUM_OBJ; i++) begin
            if (cpu_obj == IDX_W'(i + 1)) cpu_rdata = rd_arr[i];
        end
    end

    assign req_vec = val_vec & pend_vec;

    msgobj_irq_pri #(.N(NUM_OBJ), .IDX_W(IDX_W)) u_pri (
        .req (req_vec),
        .any (irq),
        .idx (irq_obj)
    );

    p_irq_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_obj != '0 && val_vec[int'(irq_obj) - 1] && pend_vec[int'(irq_obj) - 1]));
    p_irq_lowest_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((req_vec & ((NUM_OBJ'(1) << (int'(irq_obj) - 1)) - NUM_OBJ'(1))) == '0));
    p_irq_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (irq_obj == '0 && (val_vec & pend_vec) == '0));

endmodule

// File: tb/tb_msgobj_bank.sv
module tb_msgobj_bank;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cpu_addr = '0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        eng_rx_store = 1'b0;
    logic        eng_tx_done = 1'b0;
    logic [3:0]  eng_obj = '0;
    logic [31:0] eng_id = '0;
    logic [63:0] eng_data = '0;
    logic        irq;
    logic [3:0]  irq_obj;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msgobj_bank dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .eng_rx_store(eng_rx_store),
        .eng_tx_done(eng_tx_done), .eng_obj(eng_obj), .eng_id(eng_id),
        .eng_data(eng_data), .irq(irq), .irq_obj(irq_obj)
    );

    function automatic logic [7:0] pat(input int o, input int k);
        return 8'((o * 16 + k) ^ 8'hA5);
    endfunction

    function automatic logic [7:0] enc4(input logic [3:0] f);
        logic [7:0] b;
        for (int i = 0; i < 4; i++) b[2*i +: 2] = f[i] ? 2'b10 : 2'b01;
        return b;
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        cpu_addr = a;
        #1;
        d = cpu_rdata;
    endtask

    task automatic rx_store(input logic [3:0] o, input logic [31:0] id, input logic [63:0] dt);
        @(negedge clk);
        eng_obj = o; eng_id = id; eng_data = dt; eng_rx_store = 1'b1;
        @(negedge clk);
        eng_rx_store = 1'b0;
    endtask

    task automatic tx_done(input logic [3:0] o);
        @(negedge clk);
        eng_obj = o; eng_tx_done = 1'b1;
        @(negedge clk);
        eng_tx_done = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [3:0] m0, m1;
        logic [31:0] rid;
        logic [63:0] rdt;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state of every object
        for (int o = 1; o <= 15; o++) begin
            rd(8'(o*16), v);     chk(v, 8'h55, "R12 ctrl0 after reset");
            rd(8'(o*16 + 1), v); chk(v, 8'h55, "R12 ctrl1 after reset");
        end
        chk(irq, 0, "R12 irq after reset");

        // R1: plain bytes of every slot, padding and slot zero
        for (int o = 1; o <= 15; o++)
            for (int k = 2; k <= 15; k++) wr(8'(o*16 + k), pat(o, k));
        for (int a = 0; a < 16; a++) wr(8'(a), 8'hFF);
        for (int o = 1; o <= 15; o++)
            for (int k = 2; k <= 15; k++) begin
                rd(8'(o*16 + k), v);
                chk(v, (k == 15) ? 8'h00 : pat(o, k), "R1 slot byte readback");
            end
        for (int a = 0; a < 16; a++) begin
            rd(8'(a), v); chk(v, 8'h00, "R1 slot zero reads zero");
        end

        // R2 R3 R4: every field, both start states, every command code, object 3
        m0 = '0; m1 = '0;
        for (int f = 0; f < 8; f++)
            for (int s = 0; s < 2; s++)
                for (int c = 0; c < 4; c++) begin
                    logic [7:0] b;
                    int p;
                    p = f % 4;
                    b = 8'hFF; b[2*p +: 2] = (s != 0) ? 2'b10 : 2'b01;
                    wr(8'h30 + 8'(f / 4), b);
                    if (f < 4) m0[p] = (s != 0); else m1[p] = (s != 0);
                    b = 8'hFF; b[2*p +: 2] = 2'(c);
                    wr(8'h30 + 8'(f / 4), b);
                    if (c == 1) begin if (f < 4) m0[p] = 1'b0; else m1[p] = 1'b0; end
                    if (c == 2) begin if (f < 4) m0[p] = 1'b1; else m1[p] = 1'b1; end
                    rd(8'h30, v); chk(v, enc4(m0), "R2 R3 R4 ctrl0 field command");
                    rd(8'h31, v); chk(v, enc4(m1), "R2 R3 R4 ctrl1 field command");
                end
        wr(8'h30, 8'h55); wr(8'h31, 8'h55);
        rd(8'h30, v); chk(v, 8'h55, "R2 clear all fields");

        // R5: direction and extended bits, shared lost/updating bit
        wr(8'h46, 8'h0C);
        rd(8'h46, v); chk(v, 8'h0C, "R5 cfg dir and ext bits");
        wr(8'h41, 8'hFB);
        rd(8'h41, v); chk(v, enc4(4'b0010), "R5 updating field on transmit object");

        // R6 R8: receive store into object 5 (valid, rx enable, receive direction)
        wr(8'h56, 8'h00);
        wr(8'h50, 8'h9B);
        rid = 32'h12345678; rdt = 64'h1122334455667788;
        rx_store(4'd5, rid, rdt);
        for (int k = 0; k < 4; k++) begin
            rd(8'h52 + 8'(k), v); chk(v, rid[31-8*k -: 8], "R6 identifier byte order");
        end
        for (int k = 0; k < 8; k++) begin
            rd(8'h57 + 8'(k), v); chk(v, rdt[63-8*k -: 8], "R6 data byte order");
        end
        rd(8'h51, v); chk(v, enc4(4'b0001), "R6 new data set");
        rd(8'h50, v); chk(v, enc4(4'b1011), "R8 pending set by receive");
        chk({irq, irq_obj}, {1'b1, 4'd5}, "R11 irq from object 5");

        // R7: overrun
        rx_store(4'd5, 32'hCAFEF00D, 64'h0);
        rd(8'h51, v); chk(v, enc4(4'b0011), "R7 lost set on overrun");
        rd(8'h52, v); chk(v, 8'hCA, "R6 second store overwrites");

        // R9: invalid object 6, transmit-direction object 7
        rx_store(4'd6, 32'hFFFFFFFF, 64'hFFFFFFFFFFFFFFFF);
        rd(8'h62, v); chk(v, pat(6, 2), "R9 invalid object id kept");
        rd(8'h61, v); chk(v, 8'h55, "R9 invalid object flags kept");
        wr(8'h76, 8'h08);
        wr(8'h70, 8'h9B);
        rx_store(4'd7, 32'hFFFFFFFF, 64'hFFFFFFFFFFFFFFFF);
        rd(8'h77, v); chk(v, pat(7, 7), "R9 transmit object data kept");
        rd(8'h71, v); chk(v, 8'h55, "R9 transmit object flags kept");
        rd(8'h70, v); chk(v, enc4(4'b1010), "R9 transmit object pending clear");

        // R10: transmit done with and without tx enable
        wr(8'h86, 8'h08); wr(8'h80, 8'hAF); wr(8'h81, 8'hEF);
        wr(8'hA6, 8'h08); wr(8'hA0, 8'h9F); wr(8'hA1, 8'hEF);
        tx_done(4'd8);
        tx_done(4'd10);
        rd(8'h81, v); chk(v, 8'h55, "R10 request cleared obj8");
        rd(8'h80, v); chk(v, enc4(4'b1101), "R10 pending set with tx enable");
        rd(8'hA1, v); chk(v, 8'h55, "R10 request cleared obj10");
        rd(8'hA0, v); chk(v, enc4(4'b1000), "R10 no pending without tx enable");

        // R11: priority and validity gating
        chk({irq, irq_obj}, {1'b1, 4'd5}, "R11 lowest object wins");
        wr(8'h50, 8'hFD);
        chk({irq, irq_obj}, {1'b1, 4'd8}, "R11 next object after clear");
        wr(8'h90, 8'hFE);
        chk({irq, irq_obj}, {1'b1, 4'd8}, "R11 invalid object pending ignored");
        wr(8'h80, 8'hFD);
        chk({irq, irq_obj}, {1'b0, 4'd0}, "R11 idle when no valid pending");
        wr(8'h90, 8'hBF);
        chk({irq, irq_obj}, {1'b1, 4'd9}, "R11 object 9 after valid set");

        // R13: CPU clears new data in the cycle a receive store sets it
        @(negedge clk);
        cpu_addr = 8'h51; cpu_wdata = 8'hFD; cpu_wr = 1'b1;
        eng_obj = 4'd5; eng_id = 32'h0; eng_data = 64'h0; eng_rx_store = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0; eng_rx_store = 1'b0;
        rd(8'h51, v); chk(v, enc4(4'b0011), "R13 engine wins over CPU clear");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule